// File: doc/BRIEF.md
# Unit-by-Register Dependency Matrix with Latest-Writer Rename

This block records, for every function unit row and every architectural register, whether the operation held by that row must read the register and whether it will write it. Register numbers are never stored as indices. Each row keeps one wire per register. The source and destination selections therefore arrive and leave as decoded bit vectors.

Next to the write marks, each register column carries a latest-writer bit. At most one row holds it at a time. When an operation is issued with a destination, its row takes the latest-writer bit for that register, and the bit is taken away from whichever row held it before. This replaces a tag lookup in a reorder buffer. A newly issued operation presents its decoded source vectors. For each source, the block returns a one-hot-or-zero vector naming the unit that will produce the value. The unit-to-unit matrix uses this vector to place read-after-write waits. When a unit writes back, its whole row is released.

Several rows may feed one execution unit and act as reservation stations. Operand capture happens outside this block.

Top module: `dep_matrix_rename`

## Requirements
- R1: While reset is asserted, and after it is released, every need-read, need-write and latest-writer bit is zero.
- R2: A valid issue to unit u loads row u's need-read bits with the OR of all source vectors and loads its need-write bits with the destination vector (bit r stands for register r). Whatever the row held before is replaced.
- R3: In every register column, at most one unit holds the latest-writer bit at any time.
- R4: A valid issue with destination register r sets the latest-writer bit of the issuing unit at r and clears it in every other unit. The need-write bit of an older writer of r stays set until that unit writes back.
- R5: For source s, the producer output bits [s*NUNITS +: NUNITS] name, one-hot, the unit that holds the latest-writer bit of the register selected by that source. The vector is zero when no unit holds that bit or when the source vector is zero. The output is a combinational lookup of the current state.
- R6: After a register is retargeted by a newer issue, a later reader's producer vector names the newer unit and no longer names the earlier writer.
- R7: A write-back from unit u (with no issue to u in the same cycle) clears all of row u's need-read, need-write and latest-writer bits. No other row changes because of it.
- R8: When an issue and a write-back arrive in the same cycle for the same unit, the issue's result stands. For different units, both take effect.
- R9: Issue fields are ignored while issue_valid is low, and the write-back unit is ignored while wb_valid is low.
- R10: An issue with an all-zero destination vector leaves every other row's latest-writer bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An operation is issued this cycle |
| issue_unit | input | UW | Row receiving the operation |
| issue_src | input | NSRC*NREGS | Decoded source vectors, source s at [s*NREGS +: NREGS] |
| issue_dst | input | NREGS | Decoded destination vector, zero for none |
| wb_valid | input | 1 | A unit completes write-back this cycle |
| wb_unit | input | UW | Row completing write-back |
| src_producer | output | NSRC*NUNITS | Per-source one-hot-or-zero producer unit |
| need_read_o | output | NUNITS*NREGS | Need-read matrix, unit u at [u*NREGS +: NREGS] |
| need_write_o | output | NUNITS*NREGS | Need-write matrix, same layout |
| latest_o | output | NUNITS*NREGS | Latest-writer matrix, same layout |

## Verification
The bench uses the default parameters: four units, eight registers and two sources. Four rows are enough to pass one register through a chain of three writers while a fourth row reads it. With two sources, a single lookup can return two different producers, or one producer and none. The same eight-register width is small enough that every column's exclusivity is counted after each step of the walk, alongside the same-cycle issue and write-back cases.

// File: rtl/dep_matrix_rename.sv
`timescale 1ns/1ps
module dep_matrix_rename #(
  parameter int NUNITS = 4,
  parameter int NREGS  = 8,
  parameter int NSRC   = 2,
  localparam int UW    = (NUNITS > 1) ? $clog2(NUNITS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue_valid,
  input  logic [UW-1:0]           issue_unit,
  input  logic [NSRC*NREGS-1:0]   issue_src,
  input  logic [NREGS-1:0]        issue_dst,
  input  logic                    wb_valid,
  input  logic [UW-1:0]           wb_unit,
  output logic [NSRC*NUNITS-1:0]  src_producer,
  output logic [NUNITS*NREGS-1:0] need_read_o,
  output logic [NUNITS*NREGS-1:0] need_write_o,
  output logic [NUNITS*NREGS-1:0] latest_o
);
  logic [NREGS-1:0] rd_q [NUNITS];
  logic [NREGS-1:0] wr_q [NUNITS];
  logic [NREGS-1:0] lw_q [NUNITS];
  logic [NREGS-1:0] src_any;

  always_comb begin
    src_any = '0;
    for (int s = 0; s < NSRC; s++) src_any = src_any | issue_src[s*NREGS +: NREGS];
  end

  for (genvar u = 0; u < NUNITS; u++) begin : g_row
    logic iss_here, wb_here;
    assign iss_here = issue_valid && (issue_unit == UW'(u));
    assign wb_here  = wb_valid && (wb_unit == UW'(u));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q[u] <= '0;
        wr_q[u] <= '0;
        lw_q[u] <= '0;
      end else if (iss_here) begin
        rd_q[u] <= src_any;
        wr_q[u] <= issue_dst;
        lw_q[u] <= issue_dst;
      end else if (wb_here) begin
        rd_q[u] <= '0;
        wr_q[u] <= '0;
        lw_q[u] <= '0;
      end else if (issue_valid) begin
        lw_q[u] <= lw_q[u] & ~issue_dst;
      end
    end

    assign need_read_o[u*NREGS +: NREGS]  = rd_q[u];
    assign need_write_o[u*NREGS +: NREGS] = wr_q[u];
    assign latest_o[u*NREGS +: NREGS]     = lw_q[u];

    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign src_producer[s*NUNITS + u] = |(issue_src[s*NREGS +: NREGS] & lw_q[u]);
    end
  end
endmodule

// File: rtl/dep_matrix_rename_chk.sv
`timescale 1ns/1ps
module dep_matrix_rename_chk #(
  parameter int NUNITS = 4,
  parameter int NREGS  = 8,
  parameter int NSRC   = 2,
  localparam int UW    = (NUNITS > 1) ? $clog2(NUNITS) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    issue_valid,
  input logic [UW-1:0]           issue_unit,
  input logic [NSRC*NREGS-1:0]   issue_src,
  input logic [NREGS-1:0]        issue_dst,
  input logic                    wb_valid,
  input logic [UW-1:0]           wb_unit,
  input logic [NSRC*NUNITS-1:0]  src_producer,
  input logic [NUNITS*NREGS-1:0] need_read_o,
  input logic [NUNITS*NREGS-1:0] need_write_o,
  input logic [NUNITS*NREGS-1:0] latest_o
);
  logic [NREGS-1:0] lw_v [NUNITS];
  logic [NREGS-1:0] wr_v [NUNITS];
  logic [NREGS-1:0] rd_v [NUNITS];

  for (genvar u = 0; u < NUNITS; u++) begin : g_view
    assign lw_v[u] = latest_o[u*NREGS +: NREGS];
    assign wr_v[u] = need_write_o[u*NREGS +: NREGS];
    assign rd_v[u] = need_read_o[u*NREGS +: NREGS];
  end

  for (genvar r = 0; r < NREGS; r++) begin : g_col
    logic [NUNITS-1:0] col;
    for (genvar u = 0; u < NUNITS; u++) begin : g_bit
      assign col[u] = latest_o[u*NREGS + r];
    end
    // R3
    col_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col));
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_prod
    // R5
    producer_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(issue_src[s*NREGS +: NREGS]) |-> $onehot0(src_producer[s*NUNITS +: NUNITS]));
  end

  // R4
  issue_takes_latest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> (lw_v[$past(issue_unit)] == $past(issue_dst)) &&
                    (wr_v[$past(issue_unit)] == $past(issue_dst)));

  // R7
  wb_clears_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !(issue_valid && issue_unit == wb_unit)) |=>
      (lw_v[$past(wb_unit)] == '0) && (wr_v[$past(wb_unit)] == '0) && (rd_v[$past(wb_unit)] == '0));

  // R9
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_valid && !wb_valid) |=> $stable(need_read_o) && $stable(need_write_o) && $stable(latest_o));
endmodule

bind dep_matrix_rename dep_matrix_rename_chk #(.NUNITS(NUNITS), .NREGS(NREGS), .NSRC(NSRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_unit(issue_unit),
  .issue_src(issue_src), .issue_dst(issue_dst), .wb_valid(wb_valid), .wb_unit(wb_unit),
  .src_producer(src_producer), .need_read_o(need_read_o), .need_write_o(need_write_o),
  .latest_o(latest_o)
);

// File: tb/tb_dep_matrix_rename.sv
`timescale 1ns/1ps
module tb_dep_matrix_rename;
  localparam int NU = 4, NR = 8, NS = 2;

  typedef struct packed {
    logic        iv;
    logic [1:0]  iu;
    logic [7:0]  s0, s1, d;
    logic        wv;
    logic [1:0]  wu;
    logic [7:0]  prod;
    logic [31:0] lat;
  } step_t;

  localparam int NSTEP = 10;
  localparam step_t TBL [NSTEP] = '{
    '{1'b1, 2'd2, 8'h04, 8'h08, 8'h02, 1'b0, 2'd0, 8'h00, 32'h00020000}, // r1 -> unit2
    '{1'b1, 2'd0, 8'h02, 8'h08, 8'h10, 1'b0, 2'd0, 8'h04, 32'h00020010}, // R5 reader of r1
    '{1'b1, 2'd1, 8'h20, 8'h40, 8'h02, 1'b0, 2'd0, 8'h00, 32'h00000210}, // R4 retarget r1
    '{1'b1, 2'd3, 8'h02, 8'h10, 8'h80, 1'b0, 2'd0, 8'h12, 32'h80000210}, // R6 two producers
    '{1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 1'b1, 2'd1, 8'h00, 32'h80000010}, // R7 wb unit1
    '{1'b1, 2'd1, 8'h02, 8'h80, 8'h10, 1'b1, 2'd0, 8'h80, 32'h80001000}, // R8 diff units
    '{1'b1, 2'd3, 8'h10, 8'h00, 8'h01, 1'b1, 2'd3, 8'h02, 32'h01001000}, // R8 same unit
    '{1'b0, 2'd0, 8'h00, 8'h00, 8'hFF, 1'b0, 2'd1, 8'h00, 32'h01001000}, // R9 ignored
    '{1'b1, 2'd2, 8'h01, 8'h10, 8'h00, 1'b0, 2'd0, 8'h28, 32'h01001000}, // R10 no dst
    '{1'b1, 2'd0, 8'h00, 8'h00, 8'h01, 1'b0, 2'd0, 8'h00, 32'h00001001}  // R4 take r0
  };

  logic clk = 0, rst_n = 0;
  logic issue_valid = 0, wb_valid = 0;
  logic [1:0] issue_unit = 0, wb_unit = 0;
  logic [NS*NR-1:0] issue_src = 0;
  logic [NR-1:0] issue_dst = 0;
  logic [NS*NU-1:0] src_producer;
  logic [NU*NR-1:0] need_read_o, need_write_o, latest_o;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  dep_matrix_rename #(.NUNITS(NU), .NREGS(NR), .NSRC(NS)) dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_unit(issue_unit),
    .issue_src(issue_src), .issue_dst(issue_dst), .wb_valid(wb_valid), .wb_unit(wb_unit),
    .src_producer(src_producer), .need_read_o(need_read_o), .need_write_o(need_write_o),
    .latest_o(latest_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_columns();
    for (int r = 0; r < NR; r++) begin
      int n = 0;
      for (int u = 0; u < NU; u++) n += int'(latest_o[u*NR + r]);
      chk($sformatf("R3 column r%0d count", r), 64'(n > 1), 64'(0));
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 while held in reset
    chk("R1 reset matrices", 64'({need_read_o, need_write_o} | 64'(latest_o)), 64'(0));
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", 64'(latest_o), 64'(0));

    for (int i = 0; i < NSTEP; i++) begin
      @(negedge clk);
      issue_valid = TBL[i].iv; issue_unit = TBL[i].iu;
      issue_src = {TBL[i].s1, TBL[i].s0}; issue_dst = TBL[i].d;
      wb_valid = TBL[i].wv; wb_unit = TBL[i].wu;
      #1;
      chk($sformatf("R5 producer step %0d", i), 64'(src_producer), 64'(TBL[i].prod));
      @(posedge clk);
      #1;
      chk($sformatf("R4 latest step %0d", i), 64'(latest_o), 64'(TBL[i].lat));
      chk_columns();
    end

    @(negedge clk);
    issue_valid = 0; wb_valid = 0; issue_src = 0; issue_dst = 0;
    // R2 rows: u0 {rd 00, wr 01}, u1 {82,10}, u2 {11,00}, u3 {10,01}; R4 older writer u3 keeps wr r0
    chk("R2 need_read", 64'(need_read_o), 64'(32'h10118200));
    chk("R2 need_write", 64'(need_write_o), 64'(32'h01001001));

    issue_src = 16'h0010;
    #1;
    chk("R9 lookup while invalid", 64'(src_producer), 64'(8'h02));
    wb_valid = 1; wb_unit = 2'd2;
    @(posedge clk); #1;
    // R7 row 2 cleared, others unchanged
    chk("R7 need_read", 64'(need_read_o), 64'(32'h10008200));
    chk("R7 need_write", 64'(need_write_o), 64'(32'h01001001));
    chk("R7 latest", 64'(latest_o), 64'(32'h00001001));
    chk_columns();

    @(negedge clk);
    wb_valid = 0;
    rst_n = 0;
    #1;
    chk("R1 mid-run reset", 64'({need_read_o, need_write_o} | 64'(latest_o)), 64'(0));
    rst_n = 1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule